// File: doc/BRIEF.md
# RAM Write Protection Checker

This block sits in front of the on-chip SRAM and judges every bus write against a programmable map of protected blocks. The RAM window starts at address 0x20000000 and is divided into fixed-size blocks; each block owns one bit in the protection map, and a set bit marks the block as write protected. A request carries an address, a write/read flag, a privilege flag and a master identifier. Identifier 0 is the CPU. Every other identifier is a DMA-capable peripheral.

The decision is combinational and is made in the same cycle as the request. Privileged writes always reach the RAM. An unprivileged CPU write to a protected block is refused with a bus error. DMA writes are checked against the map only while a DMA-checking enable is set. A DMA write that hits a protected block is then dropped without an error to the DMA master. It raises a sticky fault flag that drives the interrupt, and it captures the faulting address and master identifier. Software programs the map and the enable through a small register port that accepts only privileged writes. The same port clears the fault flag.

Top module: `ram_wprot`

## Requirements
- R1: The block index of an in-window address is (address - 0x20000000) / BLK_BYTES, with BLK_BYTES = 32 by default. Map register k (config index k, k < MAP_WORDS) holds blocks 32k..32k+31, and bit j of that register belongs to block 32k+j.
- R2: An address below 0x20000000, or at or above 0x20000000 + RAM_BYTES, is never refused: `ram_we` follows the request and `req_err` stays low.
- R3: An unprivileged write from master 0 to a protected block drives `req_err` high and `ram_we` low in the same cycle.
- R4: A privileged write is passed to the RAM (`ram_we` high, `req_err` low) whatever the map holds.
- R5: A read never raises `req_err` and never raises `ram_we`, in either privilege mode.
- R6: While the DMA enable (config index MAP_WORDS, bit 0) is clear, a write from any master other than 0 is never refused.
- R7: While the DMA enable is set, an unprivileged write from a master other than 0 to a protected block leaves `ram_we` and `req_err` low. From the next cycle the fault flag (config index MAP_WORDS+1, bit 0) and `irq` are high, the faulting address reads back at index MAP_WORDS+2 and the master identifier at index MAP_WORDS+3.
- R8: While the fault flag is set, later DMA faults leave the captured address and identifier unchanged. A privileged config write with bit 0 set to index MAP_WORDS+1 clears the flag on the next cycle. A fault in the same cycle as that clear is captured, and the flag stays set.
- R9: Config writes with `cfg_priv` low change nothing. After reset the map, the DMA enable, the flag and the capture registers all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_priv | input | 1 | Request is privileged |
| req_master | input | MID_W | Master identifier, 0 = CPU |
| ram_we | output | 1 | Write enable to the SRAM |
| req_err | output | 1 | Bus error response for this request |
| cfg_wr | input | 1 | Config register write strobe |
| cfg_addr | input | CA_W | Config register index |
| cfg_wdata | input | 32 | Config write data |
| cfg_priv | input | 1 | Config access is privileged |
| cfg_rdata | output | 32 | Config read data for `cfg_addr` |
| irq | output | 1 | DMA protection fault interrupt (the sticky flag) |

## Verification
Assertions check on every cycle that an error and a RAM write never coincide, that reads and privileged writes are never refused, and that DMA masters never see an error. They also check that an unprivileged config write leaves the map and enable untouched, and that captured fault data stays put while the flag is set. Only the bench scenarios can show the block index arithmetic at block edges and window limits, the mapping of map bits to blocks, the first-fault-wins capture, the clear path and the clear-with-fault collision. The bench follows all of these with a behavioural model that it compares on every cycle.

// File: rtl/ram_wprot_pkg.sv
// Package: shared constants and the decision type for the RAM write
// protection checker. Assumes master identifier 0 is the CPU.
package ram_wprot_pkg;
    localparam logic [31:0] RAM_BASE = 32'h2000_0000;
    localparam int unsigned CPU_ID   = 0;

    typedef enum logic [1:0] {
        DEC_PASS    = 2'd0,   // write (or read) goes through
        DEC_BUS_ERR = 2'd1,   // refused with a bus error
        DEC_DMA_DROP= 2'd2    // DMA write silently dropped, fault raised
    } wp_dec_e;
endpackage

// File: rtl/wprot_check.sv
// Module: wprot_check
// Purely combinational verdict for one request: decodes the address into
// a block index, looks up the protection bit and applies the privilege,
// master and DMA-enable rules. Assumes RAM_BYTES is a multiple of BLK_BYTES
// and BLK_BYTES is a power of two.
module wprot_check
    import ram_wprot_pkg::*;
#(
    parameter int unsigned RAM_BYTES = 8192,
    parameter int unsigned BLK_BYTES = 32,
    parameter int unsigned MID_W     = 3,
    localparam int unsigned NBLK     = RAM_BYTES / BLK_BYTES,
    localparam int unsigned SH       = $clog2(BLK_BYTES),
    localparam int unsigned IDX_W    = $clog2(NBLK)
) (
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [31:0]      req_addr,
    input  logic             req_priv,
    input  logic [MID_W-1:0] req_master,
    input  logic [NBLK-1:0]  prot_map,
    input  logic             dma_chk_en,
    output wp_dec_e          verdict
);
    logic [31:0]      offset;
    logic             in_window;
    logic [IDX_W-1:0] blk_idx;
    logic             blk_locked;
    logic             is_cpu;

    // Address decode: offset from the RAM base, window test, block index.
    always_comb begin
        offset    = req_addr - RAM_BASE;
        in_window = (req_addr >= RAM_BASE) && (offset < 32'(RAM_BYTES));
        blk_idx   = IDX_W'(offset >> SH);
        blk_locked = in_window && prot_map[blk_idx];
        is_cpu    = (req_master == MID_W'(CPU_ID));
    end

    // Verdict: privileged and read accesses pass; others depend on master.
    always_comb begin
        verdict = DEC_PASS;
        if (req_valid && req_write && !req_priv && blk_locked) begin
            if (is_cpu)          verdict = DEC_BUS_ERR;
            else if (dma_chk_en) verdict = DEC_DMA_DROP;
        end
    end
endmodule

// File: rtl/wprot_regs.sv
// Module: wprot_regs
// Register file of the checker: protection map words, DMA-check enable,
// sticky fault flag with write-one-to-clear, and the fault capture pair.
// Only privileged config writes take effect. Index layout: 0..MAP_WORDS-1
// map, MAP_WORDS enable, +1 flag, +2 fault address, +3 fault master.
module wprot_regs #(
    parameter int unsigned NBLK  = 256,
    parameter int unsigned MID_W = 3,
    localparam int unsigned MAP_WORDS = NBLK / 32,
    localparam int unsigned CA_W  = $clog2(MAP_WORDS + 4)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CA_W-1:0]  cfg_addr,
    input  logic [31:0]      cfg_wdata,
    input  logic             cfg_priv,
    output logic [31:0]      cfg_rdata,
    input  logic             fault_evt,
    input  logic [31:0]      fault_addr_in,
    input  logic [MID_W-1:0] fault_id_in,
    output logic [NBLK-1:0]  prot_map,
    output logic             dma_chk_en,
    output logic             fault_flag
);
    localparam int unsigned IX_EN   = MAP_WORDS;
    localparam int unsigned IX_FLAG = MAP_WORDS + 1;
    localparam int unsigned IX_ADDR = MAP_WORDS + 2;
    localparam int unsigned IX_ID   = MAP_WORDS + 3;

    logic             wr_ok;
    logic             clr_req;
    logic             take_fault;
    logic [31:0]      cap_addr;
    logic [MID_W-1:0] cap_id;

    assign wr_ok      = cfg_wr && cfg_priv;
    assign clr_req    = wr_ok && (cfg_addr == CA_W'(IX_FLAG)) && cfg_wdata[0];
    assign take_fault = fault_evt && (!fault_flag || clr_req);

    // One register per map word, each written by a privileged config write.
    for (genvar w = 0; w < MAP_WORDS; w++) begin : g_map
        always_ff @(posedge clk) begin
            if (!rst_n)
                prot_map[w*32 +: 32] <= '0;
            else if (wr_ok && cfg_addr == CA_W'(w))
                prot_map[w*32 +: 32] <= cfg_wdata;
        end
    end

    // DMA-check enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  dma_chk_en <= 1'b0;
        else if (wr_ok && cfg_addr == CA_W'(IX_EN))  dma_chk_en <= cfg_wdata[0];
    end

    // Sticky fault flag: a new fault wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         fault_flag <= 1'b0;
        else if (fault_evt) fault_flag <= 1'b1;
        else if (clr_req)   fault_flag <= 1'b0;
    end

    // Fault capture: only the first fault while the flag is clear is kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_id   <= '0;
        end else if (take_fault) begin
            cap_addr <= fault_addr_in;
            cap_id   <= fault_id_in;
        end
    end

    // Read mux for the config port.
    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr < CA_W'(MAP_WORDS)) begin
            for (int w = 0; w < MAP_WORDS; w++)
                if (cfg_addr == CA_W'(w)) cfg_rdata = prot_map[w*32 +: 32];
        end else if (cfg_addr == CA_W'(IX_EN))   cfg_rdata = {31'd0, dma_chk_en};
        else if (cfg_addr == CA_W'(IX_FLAG))     cfg_rdata = {31'd0, fault_flag};
        else if (cfg_addr == CA_W'(IX_ADDR))     cfg_rdata = cap_addr;
        else if (cfg_addr == CA_W'(IX_ID))       cfg_rdata = 32'(cap_id);
    end

    // R9: an unprivileged config write leaves map and enable unchanged.
    a_r9_unpriv_cfg_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_priv) |=> ($stable(prot_map) && $stable(dma_chk_en)));

    // R8: while the flag is held and not being cleared, the capture stays put.
    a_r8_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && !clr_req) |=> ($stable(cap_addr) && $stable(cap_id)));

    // R7: the flag only rises after a DMA fault reported by the checker.
    a_r7_flag_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_flag) |-> $past(fault_evt));
endmodule

// File: rtl/ram_wprot.sv
// Module: ram_wprot (top)
// RAM write protection checker: combinational grant/error verdict per bus
// request, register port for the protection map and DMA enable, sticky
// DMA fault capture and interrupt. Assumes one request per cycle, already
// arbitrated, and that the SRAM itself lies outside this block.
module ram_wprot
    import ram_wprot_pkg::*;
#(
    parameter int unsigned RAM_BYTES = 8192,
    parameter int unsigned BLK_BYTES = 32,
    parameter int unsigned MID_W     = 3,
    localparam int unsigned NBLK      = RAM_BYTES / BLK_BYTES,
    localparam int unsigned MAP_WORDS = NBLK / 32,
    localparam int unsigned CA_W      = $clog2(MAP_WORDS + 4)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [31:0]      req_addr,
    input  logic             req_priv,
    input  logic [MID_W-1:0] req_master,
    output logic             ram_we,
    output logic             req_err,
    input  logic             cfg_wr,
    input  logic [CA_W-1:0]  cfg_addr,
    input  logic [31:0]      cfg_wdata,
    input  logic             cfg_priv,
    output logic [31:0]      cfg_rdata,
    output logic             irq
);
    logic [NBLK-1:0] prot_map;
    logic            dma_chk_en;
    logic            fault_flag;
    wp_dec_e         verdict;

    wprot_check #(.RAM_BYTES(RAM_BYTES), .BLK_BYTES(BLK_BYTES), .MID_W(MID_W)) u_check (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_priv  (req_priv),
        .req_master(req_master),
        .prot_map  (prot_map),
        .dma_chk_en(dma_chk_en),
        .verdict   (verdict)
    );

    wprot_regs #(.NBLK(NBLK), .MID_W(MID_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .cfg_priv     (cfg_priv),
        .cfg_rdata    (cfg_rdata),
        .fault_evt    (verdict == DEC_DMA_DROP),
        .fault_addr_in(req_addr),
        .fault_id_in  (req_master),
        .prot_map     (prot_map),
        .dma_chk_en   (dma_chk_en),
        .fault_flag   (fault_flag)
    );

    // Response outputs derived from the verdict.
    always_comb begin
        ram_we  = req_valid && req_write && (verdict == DEC_PASS);
        req_err = (verdict == DEC_BUS_ERR);
        irq     = fault_flag;
    end

    // R3: an error response never comes with a RAM write.
    a_r3_err_excl_we: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> !ram_we);

    // R4: privileged writes always reach the RAM.
    a_r4_priv_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_priv) |-> (ram_we && !req_err));

    // R5: reads are never refused and never write.
    a_r5_read_free: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> (!req_err && !ram_we));

    // R6/R7: DMA masters never see a bus error.
    a_r7_dma_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_master != MID_W'(CPU_ID)) |-> !req_err);
endmodule

// File: tb/tb_ram_wprot.sv
// Bench: behavioural model of the checker, compared every cycle.
module tb_ram_wprot;
    localparam int unsigned RAM_BYTES = 8192;
    localparam int unsigned BLK_BYTES = 32;
    localparam int unsigned NBLK      = RAM_BYTES / BLK_BYTES;
    localparam int unsigned NW        = NBLK / 32;
    localparam logic [31:0] BASE      = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_priv;
    logic [31:0] req_addr;
    logic [2:0]  req_master;
    logic        ram_we, req_err, irq;
    logic        cfg_wr, cfg_priv;
    logic [3:0]  cfg_addr;
    logic [31:0] cfg_wdata, cfg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Model state
    bit          m_map [NBLK];
    bit          m_en, m_flag;
    logic [31:0] m_faddr;
    logic [31:0] m_fid;

    always #4 clk = ~clk;

    ram_wprot dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_priv(req_priv), .req_master(req_master),
        .ram_we(ram_we), .req_err(req_err),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_priv(cfg_priv), .cfg_rdata(cfg_rdata), .irq(irq)
    );

    function automatic logic [31:0] m_read(input int idx);
        logic [31:0] v = '0;
        if (idx < NW) begin
            for (int j = 0; j < 32; j++) v[j] = m_map[idx*32 + j];
        end else if (idx == NW)     v = {31'd0, m_en};
        else if (idx == NW + 1)     v = {31'd0, m_flag};
        else if (idx == NW + 2)     v = m_faddr;
        else if (idx == NW + 3)     v = m_fid;
        return v;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, compare against model, advance model.
    task automatic cyc(input logic v, input logic w, input logic [31:0] a, input logic p,
                       input int m, input logic cw, input int ca, input logic [31:0] cd,
                       input logic cp, input string tag);
        longint off;
        bit inwin, prot, cpu, blk_cpu, blk_dma, clr;
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_priv = p; req_master = 3'(m);
        cfg_wr = cw; cfg_addr = 4'(ca); cfg_wdata = cd; cfg_priv = cp;
        #2;
        off     = longint'(a) - longint'(BASE);
        inwin   = (off >= 0) && (off < RAM_BYTES);
        prot    = inwin && m_map[int'(off / BLK_BYTES)];
        cpu     = (m == 0);
        blk_cpu = v && w && !p && cpu && prot;
        blk_dma = v && w && !p && !cpu && prot && m_en;
        check(tag, "ram_we",    32'(ram_we),  32'(v && w && !blk_cpu && !blk_dma));
        check(tag, "req_err",   32'(req_err), 32'(blk_cpu));
        check(tag, "irq",       32'(irq),     32'(m_flag));
        check(tag, "cfg_rdata", cfg_rdata,    m_read(ca));
        @(posedge clk);
        clr = 0;
        if (cw && cp) begin
            if (ca < NW) for (int j = 0; j < 32; j++) m_map[ca*32 + j] = cd[j];
            else if (ca == NW) m_en = cd[0];
            else if (ca == NW + 1 && cd[0]) clr = 1;
        end
        if (blk_dma && (!m_flag || clr)) begin
            m_faddr = a;
            m_fid   = 32'(m);
        end
        if (blk_dma)  m_flag = 1;
        else if (clr) m_flag = 0;
    endtask

    task automatic wr(input logic [31:0] a, input logic p, input int m, input string tag);
        cyc(1, 1, a, p, m, 0, 0, 0, 0, tag);
    endtask

    task automatic cfg(input int ca, input logic [31:0] cd, input logic cp, input string tag);
        cyc(0, 0, 0, 0, 0, 1, ca, cd, cp, tag);
    endtask

    task automatic rd_cfg(input int ca, input string tag);
        cyc(0, 0, 0, 0, 0, 0, ca, 0, 0, tag);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NBLK; i++) m_map[i] = 0;
        m_en = 0; m_flag = 0; m_faddr = '0; m_fid = '0;
        rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_priv = 0;
        req_master = '0; cfg_wr = 0; cfg_addr = '0; cfg_wdata = '0; cfg_priv = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R9 reset state of every config register
        for (int i = 0; i < NW + 4; i++) rd_cfg(i, "R9_reset");
        // R9 unprivileged config writes do nothing
        cfg(0, 32'hFFFF_FFFF, 0, "R9_unpriv_map");
        cfg(NW, 32'h1, 0, "R9_unpriv_en");
        rd_cfg(0, "R9_map_unchanged");
        rd_cfg(NW, "R9_en_unchanged");
        wr(BASE, 0, 0, "R9_no_prot");

        // R1 program blocks 0, 2 and the last block (word NW-1 bit 31)
        cfg(0, 32'h0000_0005, 1, "R1_map0");
        cfg(NW - 1, 32'h8000_0000, 1, "R1_map_last");
        rd_cfg(0, "R1_readback");
        // R3/R1 user CPU writes around block edges
        wr(BASE,                 0, 0, "R3_blk0");
        wr(BASE + 32'd31,        0, 0, "R1_blk0_end");
        wr(BASE + 32'd32,        0, 0, "R1_blk1_free");
        wr(BASE + 32'd63,        0, 0, "R1_blk1_end");
        wr(BASE + 32'd64,        0, 0, "R1_blk2");
        wr(BASE + 32'd95,        0, 0, "R1_blk2_end");
        wr(BASE + 32'd96,        0, 0, "R1_blk3_free");
        wr(BASE + RAM_BYTES - 1, 0, 0, "R3_last_byte");
        wr(BASE + RAM_BYTES - BLK_BYTES - 1, 0, 0, "R1_before_last");
        // R2 outside the window
        wr(BASE - 32'd1,         0, 0, "R2_below");
        wr(BASE + RAM_BYTES,     0, 0, "R2_above");
        // R4 privileged writes
        wr(BASE,                 1, 0, "R4_priv_cpu");
        wr(BASE + 32'd64,        1, 4, "R4_priv_dma");
        // R5 reads
        cyc(1, 0, BASE, 0, 0, 0, 0, 0, 0, "R5_user_read");
        cyc(1, 0, BASE + 32'd64, 1, 0, 0, 0, 0, 0, "R5_priv_read");
        // R6 DMA with checking disabled
        wr(BASE,                 0, 3, "R6_dma_off");
        rd_cfg(NW + 1, "R6_no_flag");

        // R7 enable DMA checking, take a fault
        cfg(NW, 32'h1, 1, "R7_enable");
        wr(BASE + 32'd70, 0, 2, "R7_dma_fault");
        rd_cfg(NW + 1, "R7_flag");
        rd_cfg(NW + 2, "R7_addr");
        rd_cfg(NW + 3, "R7_id");
        wr(BASE + 32'd40, 0, 6, "R7_dma_free_blk");
        // R8 second fault does not overwrite
        wr(BASE + 32'd4, 0, 5, "R8_second_fault");
        rd_cfg(NW + 2, "R8_addr_held");
        rd_cfg(NW + 3, "R8_id_held");
        // R9 unprivileged clear ignored, R8 privileged clear
        cfg(NW + 1, 32'h1, 0, "R9_unpriv_clear");
        rd_cfg(NW + 1, "R9_flag_kept");
        cfg(NW + 1, 32'h1, 1, "R8_clear");
        rd_cfg(NW + 1, "R8_flag_cleared");
        // R8 new fault after clear is captured
        wr(BASE + 32'd8, 0, 1, "R8_fault_after_clear");
        rd_cfg(NW + 2, "R8_new_addr");
        // R8 fault in the same cycle as a clear
        cyc(1, 1, BASE + RAM_BYTES - 2, 0, 7, 1, NW + 1, 32'h1, 1, "R8_fault_with_clear");
        rd_cfg(NW + 1, "R8_flag_stays");
        rd_cfg(NW + 2, "R8_clash_addr");
        rd_cfg(NW + 3, "R8_clash_id");
        // R6 disable again: DMA write passes, flag unaffected
        cfg(NW, 32'h0, 1, "R6_disable");
        wr(BASE + 32'd64, 0, 2, "R6_dma_off_again");
        // R3 CPU still refused while DMA checking off
        wr(BASE + 32'd65, 0, 0, "R3_cpu_again");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule